// File: doc/BRIEF.md
# Serial Converter Readout Controller

This block sits on the host side of a 24-bit delta-sigma converter whose serial output pin doubles as a data-ready flag. The converter runs as a clock slave, so this controller drives chip select, the serial clock and a channel-select line. While the host keeps `run_i` high, chip select is held low. The controller watches the shared data/ready line for a settled low level. It then clocks out one 24-bit word with a divided-down serial clock and returns the result as a signed two's-complement value with a one-cycle strobe.

When the requested channel differs from the one being driven, the channel-select output is updated between transfers. The next few completed words are thrown away, because they still hold samples taken while the converter's filter was settling. An optional byte-batch mode inserts an idle-high pause after every eighth bit. This imitates a host that moves data in bytes and relies on the converter keeping its shift position. Dropping `run_i` at any point abandons the transfer and returns the controller to idle without a result.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, `cs_n_o` is 1, `sclk_o` is 1, `res_valid_o` is 0 and `chsel_o` is 0.
- R2: `cs_n_o` is 0 while `run_i` is 1. One cycle after `run_i` is 0, `cs_n_o` and `sclk_o` are both 1.
- R3: A transfer starts only after the synchronised data/ready line has been seen high and then low on two consecutive samples. A low lasting a single system clock cycle produces no serial clock edge.
- R4: Each transfer produces exactly 24 falling edges of `sclk_o`, and `sclk_o` rests high outside transfers.
- R5: Each low phase of `sclk_o` lasts exactly `HALF_DIV` system cycles. Each high phase between bits lasts `HALF_DIV` cycles when byte-batch mode is off. `HALF_DIV` must be 3 or more.
- R6: Bits are taken MSB first, each near the end of the high phase that follows the edge on which the converter changed it. `res_data_o` is the received word with bit 23 inverted (offset binary to two's complement), so 0x800000 gives 0, 0xFFFFFF gives 0x7FFFFF and 0x000000 gives 0x800000.
- R7: `res_valid_o` is a single-cycle pulse, once per accepted word. `res_data_o` and `res_chan_o` are valid with it, and `res_chan_o` equals `chsel_o` during that transfer.
- R8: `chsel_o` takes the value of `chan_req_i` only while no bits are being clocked. After it changes, the next `SETTLE_WORDS` completed words (default 2) raise no `res_valid_o`.
- R9: With `byte_mode_i` at 1, the high phase after bit 8 and after bit 16 is `HALF_DIV + BYTE_GAP` cycles long. The word is assembled exactly as in continuous mode.
- R10: A transfer cut short by `run_i` at 0 yields no `res_valid_o`. The next transfer returns a complete, correct word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Keep converter selected and reading |
| chan_req_i | input | 1 | Requested input channel |
| byte_mode_i | input | 1 | Pause after every eighth bit |
| sdo_rdy_i | input | 1 | Shared serial data / data-ready line from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| chsel_o | output | 1 | Channel-select line to the converter |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 24 | Signed result |
| res_chan_o | output | 1 | Channel the result came from |

## Verification
`sclk_o` and `cs_n_o` come straight from registers, so each moves one cycle after the decision that changes it. The abort check therefore samples chip select on the first falling system-clock edge after the cycle in which `run_i` drops. The result strobe rises one cycle after the last cycle of the 24th high phase. A monitor running on the falling system-clock edge records every strobe, serial-clock edge and phase length, and each test task compares these records against its expectations only after the behavioural converter has released the line. Glitch rejection is judged by checking that no serial edge appears within 50 cycles. Because the data path through the two-flop synchroniser takes two cycles, ready is accepted no earlier than two cycles after the line falls.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } rd_state_e;
endpackage

// File: rtl/adcrd_rdy_filter.sv
// Two-flop synchroniser on the shared data/ready line plus a two-sample low qualifier.
module adcrd_rdy_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_s_o,
    output logic low_ok_o
);
    logic s1_q, s2_q, s3_q;
    logic s1_d, s2_d, s3_d;

    always_comb begin
        s1_d = line_i;
        s2_d = s1_q;
        s3_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
            s3_q <= 1'b1;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign line_s_o = s2_q;
    assign low_ok_o = !s2_q && !s3_q;

    // R3: a qualified low needs the raw line to have been low two and three cycles earlier
    p_low_two_samples_r3: assert property (@(posedge clk) disable iff (!rst_n)
        low_ok_o |-> (!$past(line_i, 2) && !$past(line_i, 3)));
endmodule

// File: rtl/adcrd_settle.sv
// Counts completed words that must be discarded after a channel change.
module adcrd_settle #(
    parameter int SETTLE_WORDS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    input  logic word_done_i,
    output logic discard_o
);
    localparam int SW = $clog2(SETTLE_WORDS + 2);

    logic [SW-1:0] left_q, left_d;

    always_comb begin
        left_d = left_q;
        if (chg_i)
            left_d = SW'(SETTLE_WORDS);
        else if (word_done_i && left_q != '0)
            left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign discard_o = (left_q != '0);

    generate
        if (SETTLE_WORDS > 0) begin : g_chk
            // R8: a channel change always opens the discard window
            p_change_discards_r8: assert property (@(posedge clk) disable iff (!rst_n)
                chg_i |=> discard_o);
        end
    endgenerate
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl #(
    parameter int HALF_DIV     = 10,
    parameter int BYTE_GAP     = 16,
    parameter int SETTLE_WORDS = 2,
    parameter int WORD_BITS    = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run_i,
    input  logic                 chan_req_i,
    input  logic                 byte_mode_i,
    input  logic                 sdo_rdy_i,
    output logic                 cs_n_o,
    output logic                 sclk_o,
    output logic                 chsel_o,
    output logic                 res_valid_o,
    output logic [WORD_BITS-1:0] res_data_o,
    output logic                 res_chan_o
);
    import adcrd_pkg::*;

    localparam int CNT_MAX = (HALF_DIV > BYTE_GAP) ? HALF_DIV : BYTE_GAP;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int BW      = $clog2(WORD_BITS + 1);

    typedef struct packed {
        rd_state_e            state;
        logic [CW-1:0]        cnt;
        logic [BW-1:0]        bits;
        logic [WORD_BITS-2:0] sh;
        logic                 armed;
        logic                 cs_n;
        logic                 sclk;
        logic                 chsel;
        logic                 valid;
        logic [WORD_BITS-1:0] data;
        logic                 chan;
    } rd_regs_t;

    rd_regs_t r_q, r_d;

    logic line_s, low_ok, discard;
    logic chg, done;
    logic [BW-1:0]        nb;
    logic [WORD_BITS-1:0] word;

    adcrd_rdy_filter u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (sdo_rdy_i),
        .line_s_o (line_s),
        .low_ok_o (low_ok)
    );

    adcrd_settle #(.SETTLE_WORDS(SETTLE_WORDS)) u_settle (
        .clk         (clk),
        .rst_n       (rst_n),
        .chg_i       (chg),
        .word_done_i (done),
        .discard_o   (discard)
    );

    always_comb begin
        r_d   = r_q;
        r_d.valid = 1'b0;
        chg   = 1'b0;
        done  = 1'b0;
        nb    = BW'(r_q.bits + 1'b1);
        word  = {r_q.sh, line_s};

        case (r_q.state)
            ST_IDLE: begin
                if (run_i) begin
                    r_d.cs_n  = 1'b0;
                    r_d.armed = 1'b0;
                    r_d.chsel = chan_req_i;
                    chg       = (chan_req_i != r_q.chsel);
                    r_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (chan_req_i != r_q.chsel) begin
                    r_d.chsel = chan_req_i;
                    chg       = 1'b1;
                end else if (r_q.armed && low_ok) begin
                    r_d.state = ST_LOW;
                    r_d.sclk  = 1'b0;
                    r_d.cnt   = '0;
                    r_d.bits  = '0;
                end else if (line_s) begin
                    r_d.armed = 1'b1;
                end
            end
            ST_LOW: begin
                if (r_q.cnt == CW'(HALF_DIV - 1)) begin
                    r_d.cnt   = '0;
                    r_d.sclk  = 1'b1;
                    r_d.state = ST_HIGH;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_HIGH: begin
                if (r_q.cnt == CW'(HALF_DIV - 1)) begin
                    r_d.cnt  = '0;
                    r_d.sh   = word[WORD_BITS-2:0];
                    r_d.bits = nb;
                    if (nb == BW'(WORD_BITS)) begin
                        done      = 1'b1;
                        r_d.state = ST_WAIT;
                        r_d.armed = 1'b0;
                        if (!discard) begin
                            r_d.valid = 1'b1;
                            r_d.data  = {~word[WORD_BITS-1], word[WORD_BITS-2:0]};
                            r_d.chan  = r_q.chsel;
                        end
                    end else if (byte_mode_i && nb[2:0] == 3'd0) begin
                        r_d.state = ST_GAP;
                    end else begin
                        r_d.sclk  = 1'b0;
                        r_d.state = ST_LOW;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (r_q.cnt == CW'(BYTE_GAP - 1)) begin
                    r_d.cnt   = '0;
                    r_d.sclk  = 1'b0;
                    r_d.state = ST_LOW;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (!run_i) begin
            r_d.state = ST_IDLE;
            r_d.cs_n  = 1'b1;
            r_d.sclk  = 1'b1;
            r_d.valid = 1'b0;
            r_d.cnt   = '0;
            r_d.bits  = '0;
            done      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.sclk  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o      = r_q.cs_n;
    assign sclk_o      = r_q.sclk;
    assign chsel_o     = r_q.chsel;
    assign res_valid_o = r_q.valid;
    assign res_data_o  = r_q.data;
    assign res_chan_o  = r_q.chan;

    // R2: releasing run deselects the converter on the next cycle
    p_cs_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cs_n_o && sclk_o));
    // R4: the serial clock rests high while deselected
    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);
    // R7: the result strobe never lasts two cycles
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);
    // R8: channel select holds while a bit is being clocked
    p_chsel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_o |=> $stable(chsel_o));
    // R10: an abort never yields a result
    p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !res_valid_o);
endmodule

// File: tb/tb_adc_readout_ctrl.sv
module tb_adc_readout_ctrl;
    localparam int HALF = 10;
    localparam int GAP  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_i = 1'b0;
    logic chan_req_i = 1'b0;
    logic byte_mode_i = 1'b0;
    logic sdo_rdy_i = 1'b1;
    logic cs_n_o, sclk_o, chsel_o, res_valid_o, res_chan_o;
    logic [23:0] res_data_o;

    int total = 0;
    int bad = 0;

    adc_readout_ctrl #(.HALF_DIV(HALF), .BYTE_GAP(GAP), .SETTLE_WORDS(2), .WORD_BITS(24)) dut (
        .clk(clk), .rst_n(rst_n), .run_i(run_i), .chan_req_i(chan_req_i),
        .byte_mode_i(byte_mode_i), .sdo_rdy_i(sdo_rdy_i), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .chsel_o(chsel_o), .res_valid_o(res_valid_o),
        .res_data_o(res_data_o), .res_chan_o(res_chan_o)
    );

    always #5 clk = ~clk;

    // behavioural converter: shifts the next bit after every falling serial edge
    logic [23:0] m_word = '0;
    int ptr = 0;
    always @(negedge sclk_o) begin
        if (!cs_n_o && ptr < 24) begin
            sdo_rdy_i = m_word[23 - ptr];
            ptr = ptr + 1;
        end
    end
    always @(posedge cs_n_o) begin
        ptr = 0;
        sdo_rdy_i = 1'b1;
    end

    // monitor, sampled away from the active edge
    int fall_cnt = 0, long_cnt = 0, run_len = 0;
    int min_low = 1000, max_low = 0, min_high = 1000;
    int vcnt = 0;
    logic [23:0] vdata = '0;
    logic vchan = 1'b0;
    logic sclk_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk_o != sclk_prev) begin
                if (!sclk_o) begin
                    if (fall_cnt > 0) begin
                        if (run_len < min_high) min_high = run_len;
                        if (run_len == HALF + GAP) long_cnt = long_cnt + 1;
                    end
                    fall_cnt = fall_cnt + 1;
                end else begin
                    if (run_len < min_low) min_low = run_len;
                    if (run_len > max_low) max_low = run_len;
                end
                run_len = 1;
            end else begin
                run_len = run_len + 1;
            end
            sclk_prev = sclk_o;
            if (res_valid_o) begin
                vcnt  = vcnt + 1;
                vdata = res_data_o;
                vchan = res_chan_o;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic present(input logic [23:0] w);
        m_word = w;
        ptr = 0;
        fall_cnt = 0;
        long_cnt = 0;
        sdo_rdy_i = 1'b1;
        repeat (5) @(negedge clk);
        sdo_rdy_i = 1'b0;
        wait (ptr == 24 || cs_n_o);
        if (!cs_n_o) begin
            @(posedge sclk_o);
            repeat (HALF + 3) @(negedge clk);
            sdo_rdy_i = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs_n", cs_n_o, 1);
        chk("R1 sclk", sclk_o, 1);
        chk("R1 valid", res_valid_o, 0);
        chk("R1 chsel", chsel_o, 0);
    endtask

    task automatic read_one(input logic [23:0] w, input logic [23:0] exp);
        int v0;
        v0 = vcnt;
        present(w);
        chk("R7 one strobe", vcnt - v0, 1);
        chk("R6 data", vdata, exp);
        chk("R7 chan", vchan, chsel_o);
        chk("R4 falls", fall_cnt, 24);
    endtask

    task automatic t_basic();
        run_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 cs low", cs_n_o, 0);
        read_one(24'h800000, 24'h000000);
        read_one(24'hFFFFFF, 24'h7FFFFF);
        read_one(24'h000000, 24'h800000);
        read_one(24'h3A5C96, 24'hBA5C96);
        chk("R5 min low", min_low, HALF);
        chk("R5 max low", max_low, HALF);
        chk("R5 min high", min_high, HALF);
        chk("R4 idle high", sclk_o, 1);
    endtask

    task automatic t_glitch();
        fall_cnt = 0;
        repeat (6) @(negedge clk);
        sdo_rdy_i = 1'b0;
        @(negedge clk);
        sdo_rdy_i = 1'b1;
        repeat (50) @(negedge clk);
        chk("R3 no edge on glitch", fall_cnt, 0);
        read_one(24'h123456, 24'h923456);
    endtask

    task automatic t_chan();
        int v0;
        chan_req_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 chsel follows", chsel_o, 1);
        v0 = vcnt;
        present(24'h111111);
        present(24'h222222);
        chk("R8 settle discard", vcnt - v0, 0);
        present(24'hA00001);
        chk("R8 first after settle", vcnt - v0, 1);
        chk("R8 data", vdata, 24'h200001);
        chk("R7 chan tag", vchan, 1);
    endtask

    task automatic t_burst();
        byte_mode_i = 1'b1;
        read_one(24'hC3A55A, 24'h43A55A);
        chk("R9 byte gaps", long_cnt, 2);
        byte_mode_i = 1'b0;
    endtask

    task automatic t_abort();
        int v0;
        v0 = vcnt;
        fork
            present(24'h5A5A5A);
            begin
                wait (fall_cnt == 10);
                @(negedge clk);
                run_i = 1'b0;
                @(negedge clk);
                chk("R2 cs release", cs_n_o, 1);
                chk("R2 sclk release", sclk_o, 1);
            end
        join
        repeat (HALF * 6) @(negedge clk);
        chk("R10 no result", vcnt - v0, 0);
        run_i = 1'b1;
        repeat (3) @(negedge clk);
        read_one(24'h0F0F0F, 24'h8F0F0F);
        chk("R10 fresh word count", fall_cnt, 24);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_glitch();
        t_chan();
        t_burst();
        t_abort();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule